// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a 32-pin general-purpose I/O port driven from a simple 32-bit register port. Software changes the direction of pins by writing ones into a "make output" register or a "make input" register. Pins not named in the write keep their direction. Each half of the port has its own output register. The upper 16 bits of a write to it are a per-pin write mask, so one pin can be changed without reading the register first and writing it back. A separate register returns the pin levels after they pass through a synchronizer.

The register port accepts one access in every cycle and never stalls. For that reason it carries no valid/ready pair. A write takes effect at the clock edge where `reg_wr_en` is high. Read data is combinational from `reg_addr`. Toward the pads the block drives an output-enable and an output value for each pin, and it samples each pin's input level.

Register offsets, in bytes. A word-aligned address must match exactly.
- 0x00: set to output
- 0x04: set to input, which also reads the direction word
- 0x08: output, pins 15:0
- 0x0C: output, pins 31:16
- 0x10: pin levels

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, `pad_oe` and `pad_out` are all zero, and reads of 0x04, 0x08 and 0x0C return 0.
- R2: A write to offset 0x00 makes each pin whose data bit is 1 an output (`pad_oe` bit = 1) from the next cycle. Data bits that are 0 leave the direction of their pin unchanged.
- R3: A write to offset 0x04 makes each pin whose data bit is 1 an input (`pad_oe` bit = 0). Data bits that are 0 leave the direction of their pin unchanged. A read of 0x04 returns `pad_oe`, with bit n for pin n.
- R4: A write to offset 0x08 updates pins 0 to 15. Write bit 16+n is the mask for pin n and write bit n is its new value. Only masked-in pins change, and pins 16 to 31 are untouched.
- R5: A write to offset 0x0C updates pins 16 to 31 in the same way. Write bit 16+k is the mask for pin 16+k and write bit k is its value. Pins 0 to 15 are untouched.
- R6: A read of 0x08 or 0x0C returns zeros in bits 31:16 and the current output values of that half in bits 15:0.
- R7: A read of 0x10 returns the level of every pad input through a two-flop synchronizer. A level present at a rising edge is visible at the read port after the following rising edge.
- R8: The output value of a pin is held and driven on `pad_out` whatever its direction. A value loaded while the pin is an input appears unchanged when the pin becomes an output, and it stays when the pin returns to input.
- R9: Writes to 0x10, to unaligned addresses and to any other offset change no output or direction. Reads of 0x00 and of any undefined offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wr_en | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 32 | Asynchronous pin levels from the pads |
| pad_oe | output | 32 | Per-pin output enable, 1 = drive |
| pad_out | output | 32 | Per-pin output value |

## Verification
The direction and output registers drive the pads directly, with no logic in between. A wrong bit in them therefore shows on `pad_oe` or `pad_out` at the edge of the write that caused it. A mask bit that is decoded into the wrong lane or half changes a neighbouring pin in that same cycle. A synchronizer with too few or too many stages shifts the read of 0x10 by one cycle. The bench samples that read both before and after the second edge, so the shift is caught. Writes to ignored offsets are followed at once by a check of both pad vectors.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int N_HALF = DATA_W / HALF_W;

  localparam int OFS_DIR_SET = 'h00;
  localparam int OFS_DIR_CLR = 'h04;
  localparam int OFS_OUT_LO  = 'h08;
  localparam int OFS_OUT_HI  = 'h0C;
  localparam int OFS_PIN_IN  = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR_SET,
    SEL_DIR_CLR,
    SEL_OUT_LO,
    SEL_OUT_HI,
    SEL_PIN_IN
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] oe_q
);
  logic [W-1:0] set_bits, clr_bits;

  assign set_bits = set_we ? wdata : '0;
  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= '0;
    else        oe_q <= (oe_q | set_bits) & ~clr_bits;
  end
endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half #(
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2*HW-1:0] wdata,
  output logic [HW-1:0] val_q
);
  logic [HW-1:0] lane_mask, lane_val;

  assign lane_mask = wdata[2*HW-1:HW];
  assign lane_val  = wdata[HW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= '0;
    else if (we) val_q <= (val_q & ~lane_mask) | (lane_val & lane_mask);
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_oe,
  output logic [31:0]       pad_out
);
  reg_sel_e            sel;
  logic [DATA_W-1:0]   pin_sync;
  logic [DATA_W-1:0]   oe_q;
  logic [DATA_W-1:0]   out_q;

  always_comb begin
    sel = SEL_NONE;
    if      (reg_addr == ADDR_W'(OFS_DIR_SET)) sel = SEL_DIR_SET;
    else if (reg_addr == ADDR_W'(OFS_DIR_CLR)) sel = SEL_DIR_CLR;
    else if (reg_addr == ADDR_W'(OFS_OUT_LO))  sel = SEL_OUT_LO;
    else if (reg_addr == ADDR_W'(OFS_OUT_HI))  sel = SEL_OUT_HI;
    else if (reg_addr == ADDR_W'(OFS_PIN_IN))  sel = SEL_PIN_IN;
  end

  gpio_in_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_dir_reg #(.W(DATA_W)) u_dir (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (reg_wr_en && sel == SEL_DIR_SET),
    .clr_we (reg_wr_en && sel == SEL_DIR_CLR),
    .wdata  (reg_wdata),
    .oe_q   (oe_q)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    localparam reg_sel_e MY_SEL = (h == 0) ? SEL_OUT_LO : SEL_OUT_HI;
    gpio_out_half #(.HW(HALF_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_wr_en && sel == MY_SEL),
      .wdata (reg_wdata),
      .val_q (out_q[h*HALF_W +: HALF_W])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_DIR_CLR: reg_rdata = oe_q;
      SEL_OUT_LO:  reg_rdata = {{HALF_W{1'b0}}, out_q[HALF_W-1:0]};
      SEL_OUT_HI:  reg_rdata = {{HALF_W{1'b0}}, out_q[DATA_W-1:HALF_W]};
      SEL_PIN_IN:  reg_rdata = pin_sync;
      default:     reg_rdata = '0;
    endcase
  end

  assign pad_oe  = oe_q;
  assign pad_out = out_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [31:0]       pad_in,
  input logic [31:0]       pad_oe,
  input logic [31:0]       pad_out
);
  logic hit_set, hit_clr, hit_lo, hit_hi, hit_in;
  logic [1:0] up_cnt;

  assign hit_set = reg_addr == ADDR_W'(OFS_DIR_SET);
  assign hit_clr = reg_addr == ADDR_W'(OFS_DIR_CLR);
  assign hit_lo  = reg_addr == ADDR_W'(OFS_OUT_LO);
  assign hit_hi  = reg_addr == ADDR_W'(OFS_OUT_HI);
  assign hit_in  = reg_addr == ADDR_W'(OFS_PIN_IN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  AST_DIR_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && hit_set |=> (pad_oe & $past(reg_wdata)) == $past(reg_wdata)); // R2
  AST_DIR_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && hit_clr |=> (pad_oe & $past(reg_wdata)) == '0); // R3
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && (hit_set || hit_clr)) |=> $stable(pad_oe)); // R9
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && (hit_lo || hit_hi)) |=> $stable(pad_out)); // R8
  AST_LO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && hit_lo |=> $stable(pad_out[31:16]) &&
      (((pad_out[15:0] ^ $past(pad_out[15:0])) & ~$past(reg_wdata[31:16])) == '0)); // R4
  AST_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && hit_hi |=> $stable(pad_out[15:0]) &&
      (((pad_out[31:16] ^ $past(pad_out[31:16])) & ~$past(reg_wdata[31:16])) == '0)); // R5
  AST_OUT_RD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lo || hit_hi) |-> reg_rdata[31:16] == '0); // R6
  AST_UNDEF_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_clr || hit_lo || hit_hi || hit_in) |-> reg_rdata == '0); // R9

  if (SYNC_STAGES == 2) begin : g_sync_chk
    AST_PIN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      hit_in && up_cnt >= 2'd2 |-> reg_rdata == $past(pad_in, 2)); // R7
  end
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr_en (reg_wr_en),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .pad_in    (pad_in),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out)
);

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe, pad_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk, .rst_n, .reg_addr, .reg_wr_en, .reg_wdata, .reg_rdata,
    .pad_in, .pad_oe, .pad_out
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = 8'hFC;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 oe", pad_oe, 32'h0);
    check("R1 out", pad_out, 32'h0);
    rd(8'h04, v); check("R1 dir read", v, 32'h0);
    rd(8'h08, v); check("R1 lo read", v, 32'h0);
    rd(8'h0C, v); check("R1 hi read", v, 32'h0);
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(8'h00, 32'h0000_00F0); check("R2 set", pad_oe, 32'h0000_00F0);
    wr(8'h00, 32'h0F00_0000); check("R2 zero bits keep", pad_oe, 32'h0F00_00F0);
    wr(8'h04, 32'h0000_0030); check("R3 clear", pad_oe, 32'h0F00_00C0);
    rd(8'h04, v);             check("R3 read dir", v, 32'h0F00_00C0);
  endtask

  task automatic t_out();
    logic [31:0] v;
    wr(8'h08, 32'h0005_FFFF); check("R4 mask set", pad_out, 32'h0000_0005);
    wr(8'h08, 32'h0004_0000); check("R4 mask clr", pad_out, 32'h0000_0001);
    wr(8'h08, 32'h0000_FFFF); check("R4 no mask", pad_out, 32'h0000_0001);
    wr(8'h0C, 32'h8001_FFFF); check("R5 high half", pad_out, 32'h8001_0001);
    rd(8'h08, v); check("R6 lo read", v, 32'h0000_0001);
    rd(8'h0C, v); check("R6 hi read", v, 32'h0000_8001);
  endtask

  task automatic t_retain();
    wr(8'h04, 32'hFFFF_FFFF); check("R8 all input", pad_oe, 32'h0);
    wr(8'h08, 32'h0100_0100); check("R8 load while input", pad_out, 32'h8001_0101);
    wr(8'h00, 32'h0000_0100); check("R8 oe on", pad_oe, 32'h0000_0100);
    check("R8 value kept", pad_out, 32'h8001_0101);
    wr(8'h04, 32'h0000_0100); check("R8 back to input", pad_out, 32'h8001_0101);
  endtask

  task automatic t_input();
    @(negedge clk);
    pad_in = 32'hA5A5_1234; reg_addr = 8'h10;
    @(negedge clk); #1 check("R7 one edge", reg_rdata, 32'h0);
    @(negedge clk); #1 check("R7 two edges", reg_rdata, 32'hA5A5_1234);
    pad_in = 32'h0F0F_F0F0;
    @(negedge clk); #1 check("R7 change hold", reg_rdata, 32'hA5A5_1234);
    @(negedge clk); #1 check("R7 change seen", reg_rdata, 32'h0F0F_F0F0);
  endtask

  task automatic t_undef();
    logic [31:0] v;
    wr(8'h00, 32'h0000_0003);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h09, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    check("R9 oe untouched", pad_oe, 32'h0000_0003);
    check("R9 out untouched", pad_out, 32'h8001_0101);
    rd(8'h00, v); check("R9 read set reg", v, 32'h0);
    rd(8'h14, v); check("R9 read undef", v, 32'h0);
    rd(8'h0A, v); check("R9 read unaligned", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_dir();
    t_out();
    t_retain();
    t_input();
    t_undef();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule